// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block produces one divided clock channel from an input clock. Each divider stage has two 4-bit counts, one for how long the output stays high and one for how long it stays low, so the duty cycle and the ratio are set separately. A stage can also delay its first edge by a programmed number of cycles after a restart, and it can begin in either the high or the low phase. With the default parameters a second stage follows the first and counts the first stage's rising edges, so the two ratios multiply. Either stage can be bypassed. With both stages bypassed, the input clock goes straight to the output. A force-high control overrides everything else.

All channel settings are captured into shadow registers only when the update strobe is pulsed. That same strobe restarts both stages from their programmed start state. An external SYNC input passes through a synchroniser. While it is held, the divider is parked at its start level, so several channels released together stay phase-aligned. A no-sync setting makes the channel ignore SYNC.

Top module: `cdiv_channel`

## Requirements
- R1: With a high count H and a low count L (4 bits each, values 0..15), a stage keeps its level high for H+1 and low for L+1 of its advance cycles, which gives a period of H+L+2 cycles.
- R2: After a restart, a stage with phase offset O (4 bits) keeps its start level for O extra advance cycles before its normal high/low sequence begins.
- R3: The start-high bit selects the level a stage takes on a restart: 1 starts in the high phase, 0 starts in the low phase.
- R4: While force-high is set, clk_out is 1 in both halves of the input clock, whatever the count and bypass settings are.
- R5: With both stage bypass bits set and force-high clear, clk_out follows clk_in: it is high during the high half of the input clock and low during the low half.
- R6: The second stage advances once per rising edge of the first stage's level, so the overall ratio is the product of the two stage ratios. If the first stage is bypassed, the second stage advances every input cycle. If the second stage is bypassed, the first stage's level is the output.
- R7: sync_in passes through two flip-flops. While the synchronised SYNC is high, both stages are held at their start state and the output shows the final stage's start level. On the input edge after the synchronised SYNC falls, counting resumes from that start state. With sync_in dropped just before an input edge B, the start state is shown after edge B+1, and the first count happens at edge B+2.
- R8: When the no-sync bit is set, a pulse on sync_in has no effect on clk_out.
- R9: Changes on the configuration inputs do nothing until upd_stb is high at a rising edge. At that edge the new settings are taken and both stages restart, so the start state is shown right after that edge and the first count happens on the next edge.
- R10: While rst_n is low, every setting is cleared and clk_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to divide |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Asynchronous restart request |
| upd_stb | input | 1 | Captures the configuration inputs and restarts the divider |
| s1_hi | input | CNT_W | First stage high-phase count |
| s1_lo | input | CNT_W | First stage low-phase count |
| s1_ofs | input | OFS_W | First stage phase offset |
| s1_start_hi | input | 1 | First stage starts high |
| s1_bypass | input | 1 | First stage bypassed |
| s2_hi | input | CNT_W | Second stage high-phase count |
| s2_lo | input | CNT_W | Second stage low-phase count |
| s2_ofs | input | OFS_W | Second stage phase offset |
| s2_start_hi | input | 1 | Second stage starts high |
| s2_bypass | input | 1 | Second stage bypassed |
| force_hi | input | 1 | Holds the output high |
| no_sync | input | 1 | Ignore sync_in |
| clk_out | output | 1 | Divided clock |

## Verification
A single stage is swept over every high and low count from 0 to 3, phase offsets from 0 to 2 and both start levels. This separates an off-by-one in either phase from a wrong offset or a wrong start level. One run at the maximum count and offset checks the top of the 4-bit ranges. Cascaded runs use different counts, offsets and start levels in each stage, and some run with the first stage bypassed. These show whether the second stage advances on rising edges only and whether the ratios multiply. Separate runs cover SYNC held and then released, SYNC with no-sync set, settings changed without an update strobe, forcing high, and full bypass. Each run tells apart the hold level, the restart alignment, and the shadow capture.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

   // Per-stage mode bits kept in the shadow register
   typedef struct packed {
      logic start_hi;
      logic bypass;
   } cdiv_mode_t;

   localparam int unsigned CDIV_MIN_SYNC = 2;

endpackage

// File: rtl/cdiv_sync.sv
module cdiv_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   initial begin
      assert (STAGES >= cdiv_pkg::CDIV_MIN_SYNC)
         else $error("cdiv_sync: STAGES below minimum");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/cdiv_shadow.sv
module cdiv_shadow #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   initial begin
      assert (W >= 1) else $error("cdiv_shadow: W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= d;
   end

endmodule

// File: rtl/cdiv_stage.sv
module cdiv_stage #(
   parameter int unsigned CNT_W = 4,
   parameter int unsigned OFS_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             adv,
   input  logic [CNT_W-1:0] hi,
   input  logic [CNT_W-1:0] lo,
   input  logic [OFS_W-1:0] ofs_init,
   input  logic             start_init,
   output logic             lvl,
   output logic             rise_next
);

   initial begin
      assert (CNT_W >= 1 && OFS_W >= 1)
         else $error("cdiv_stage: field widths must be positive");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [OFS_W-1:0] ofs_q;
   logic             lvl_q;
   logic             at_end;
   logic             ofs_busy;

   assign at_end    = (cnt_q == (lvl_q ? hi : lo));
   assign ofs_busy  = (ofs_q != '0);
   assign rise_next = adv && !restart && !ofs_busy && !lvl_q && at_end;
   assign lvl       = lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ofs_q <= '0;
         lvl_q <= 1'b0;
      end else if (restart) begin
         cnt_q <= '0;
         ofs_q <= ofs_init;
         lvl_q <= start_init;
      end else if (adv) begin
         if (ofs_busy) begin
            ofs_q <= ofs_q - 1'b1;
         end else if (at_end) begin
            lvl_q <= ~lvl_q;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R1
   phase_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_q ? (cnt_q <= hi) : (cnt_q <= lo));

   // R2
   ofs_hold_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !restart && ofs_busy) |=> (lvl_q == $past(lvl_q)));

   // R1
   rise_then_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_next |=> lvl_q);

endmodule

// File: rtl/cdiv_channel.sv
module cdiv_channel
   import cdiv_pkg::*;
#(
   parameter int unsigned CNT_W       = 4,
   parameter int unsigned OFS_W       = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          TWO_STAGE   = 1'b1
) (
   input  logic             clk_in,
   input  logic             rst_n,
   input  logic             sync_in,
   input  logic             upd_stb,
   input  logic [CNT_W-1:0] s1_hi,
   input  logic [CNT_W-1:0] s1_lo,
   input  logic [OFS_W-1:0] s1_ofs,
   input  logic             s1_start_hi,
   input  logic             s1_bypass,
   input  logic [CNT_W-1:0] s2_hi,
   input  logic [CNT_W-1:0] s2_lo,
   input  logic [OFS_W-1:0] s2_ofs,
   input  logic             s2_start_hi,
   input  logic             s2_bypass,
   input  logic             force_hi,
   input  logic             no_sync,
   output logic             clk_out
);

   localparam int unsigned NSTG = TWO_STAGE ? 2 : 1;
   localparam int unsigned SH_W = 2 * CNT_W + OFS_W + $bits(cdiv_mode_t);

   initial begin
      assert (SYNC_STAGES >= CDIV_MIN_SYNC)
         else $error("cdiv_channel: SYNC_STAGES too small");
   end

   // raw configuration gathered per stage
   logic [CNT_W-1:0] raw_hi   [2];
   logic [CNT_W-1:0] raw_lo   [2];
   logic [OFS_W-1:0] raw_ofs  [2];
   cdiv_mode_t       raw_mode [2];

   assign raw_hi[0]   = s1_hi;
   assign raw_lo[0]   = s1_lo;
   assign raw_ofs[0]  = s1_ofs;
   assign raw_mode[0] = '{start_hi: s1_start_hi, bypass: s1_bypass};
   assign raw_hi[1]   = s2_hi;
   assign raw_lo[1]   = s2_lo;
   assign raw_ofs[1]  = s2_ofs;
   assign raw_mode[1] = '{start_hi: s2_start_hi, bypass: s2_bypass};

   // channel-wide shadow bits
   logic [1:0] glb_q;
   logic       frc_sh;
   logic       nosync_sh;

   cdiv_shadow #(.W(2)) glb_shadow_i (
      .clk   (clk_in),
      .rst_n (rst_n),
      .ld    (upd_stb),
      .d     ({force_hi, no_sync}),
      .q     (glb_q)
   );
   assign {frc_sh, nosync_sh} = glb_q;

   // synchronised restart request
   logic sync_s;
   logic hold;
   logic restart;

   cdiv_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk_in),
      .rst_n (rst_n),
      .d     (sync_in),
      .q     (sync_s)
   );

   assign hold    = sync_s && !nosync_sh;
   assign restart = upd_stb || hold;

   // per-stage shadow and divider
   logic [CNT_W-1:0] sh_hi    [NSTG];
   logic [CNT_W-1:0] sh_lo    [NSTG];
   logic [OFS_W-1:0] sh_ofs   [NSTG];
   cdiv_mode_t       sh_mode  [NSTG];
   logic [OFS_W-1:0] init_ofs [NSTG];
   logic [NSTG-1:0]  init_start;
   logic [NSTG-1:0]  sh_byp;
   logic [NSTG-1:0]  sh_start;
   logic [NSTG-1:0]  lvl;
   logic [NSTG-1:0]  rise;
   logic [NSTG-1:0]  adv;

   for (genvar i = 0; i < NSTG; i++) begin : g_stg
      logic [SH_W-1:0] sh_q;

      cdiv_shadow #(.W(SH_W)) stg_shadow_i (
         .clk   (clk_in),
         .rst_n (rst_n),
         .ld    (upd_stb),
         .d     ({raw_hi[i], raw_lo[i], raw_ofs[i], raw_mode[i]}),
         .q     (sh_q)
      );
      assign {sh_hi[i], sh_lo[i], sh_ofs[i], sh_mode[i]} = sh_q;
      assign sh_byp[i]   = sh_mode[i].bypass;
      assign sh_start[i] = sh_mode[i].start_hi;

      // restart values come from the incoming settings on an update
      assign init_ofs[i]   = upd_stb ? raw_ofs[i] : sh_ofs[i];
      assign init_start[i] = upd_stb ? raw_mode[i].start_hi : sh_start[i];

      if (i == 0) begin : g_first
         assign adv[i] = 1'b1;
      end else begin : g_casc
         assign adv[i] = sh_byp[i-1] || rise[i-1];

         // R6
         casc_step_on_rise_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
            (!$past(restart) && !$past(sh_byp[i-1]) && (lvl[i] != $past(lvl[i])))
               |-> $past(rise[i-1]));
      end

      cdiv_stage #(.CNT_W(CNT_W), .OFS_W(OFS_W)) stage_i (
         .clk        (clk_in),
         .rst_n      (rst_n),
         .restart    (restart),
         .adv        (adv[i]),
         .hi         (sh_hi[i]),
         .lo         (sh_lo[i]),
         .ofs_init   (init_ofs[i]),
         .start_init (init_start[i]),
         .lvl        (lvl[i]),
         .rise_next  (rise[i])
      );
   end

   // output selection
   logic fin_lvl;
   logic fin_start;
   logic all_byp;

   if (NSTG == 2) begin : g_out2
      assign fin_lvl   = sh_byp[1] ? lvl[0] : lvl[1];
      assign fin_start = sh_byp[1] ? sh_start[0] : sh_start[1];
      assign all_byp   = sh_byp[0] && sh_byp[1];
   end else begin : g_out1
      assign fin_lvl   = lvl[0];
      assign fin_start = sh_start[0];
      assign all_byp   = sh_byp[0];
   end

   always_comb begin
      if (frc_sh)       clk_out = 1'b1;
      else if (all_byp) clk_out = clk_in;
      else              clk_out = fin_lvl;
   end

   // R7
   sync_park_lvl_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
      (hold && !upd_stb) |=> (fin_lvl == $past(fin_start)));

endmodule

// File: tb/cdiv_channel_tb_top.sv
module cdiv_channel_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sync_in = 1'b0;
   logic       upd = 1'b0;
   logic [3:0] h1 = '0, l1 = '0, o1 = '0, h2 = '0, l2 = '0, o2 = '0;
   logic       s1 = 1'b0, b1 = 1'b0, s2 = 1'b0, b2 = 1'b0, frc = 1'b0, nsy = 1'b0;
   logic       clk_out;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   // settings captured by the last update
   int ah1, al1, ao1, ah2, al2, ao2;
   bit as1, ab1, as2, ab2;

   always #5 clk = ~clk;

   cdiv_channel dut_i (
      .clk_in      (clk),
      .rst_n       (rst_n),
      .sync_in     (sync_in),
      .upd_stb     (upd),
      .s1_hi       (h1),
      .s1_lo       (l1),
      .s1_ofs      (o1),
      .s1_start_hi (s1),
      .s1_bypass   (b1),
      .s2_hi       (h2),
      .s2_lo       (l2),
      .s2_ofs      (o2),
      .s2_start_hi (s2),
      .s2_bypass   (b2),
      .force_hi    (frc),
      .no_sync     (nsy),
      .clk_out     (clk_out)
   );

   // level of one stage after m advance steps from its start state
   function automatic bit st_lvl(int m, int h, int l, int o, bit s);
      int mm, p, a;
      if (m <= o) return s;
      mm = m - o;
      p  = h + l + 2;
      a  = s ? h + 1 : l + 1;
      return ((mm % p) < a) ? s : !s;
   endfunction

   function automatic bit exp_out(int j);
      int n;
      if (ab2) return st_lvl(j, ah1, al1, ao1, as1);
      if (ab1) begin
         n = j;
      end else begin
         n = 0;
         for (int m = 1; m <= j; m++)
            if (st_lvl(m, ah1, al1, ao1, as1) && !st_lvl(m - 1, ah1, al1, ao1, as1)) n++;
      end
      return st_lvl(n, ah2, al2, ao2, as2);
   endfunction

   task automatic chk(logic got, bit exp, string req, string what);
      nchk++;
      if (got !== exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, got, exp, $time);
      end
   endtask

   task automatic apply();
      @(negedge clk);
      upd = 1'b1;
      ah1 = h1; al1 = l1; ao1 = o1; as1 = s1; ab1 = b1;
      ah2 = h2; al2 = l2; ao2 = o2; as2 = s2; ab2 = b2;
      @(negedge clk);
      upd = 1'b0;
   endtask

   // checks sample 0 at the current falling edge, then one per falling edge
   task automatic run(int n, string req);
      for (int j = 0; j < n; j++) begin
         if (j > 0) @(negedge clk);
         chk(clk_out, exp_out(j), req, $sformatf("sample %0d", j));
      end
   endtask

   task automatic casc(int xh1, int xl1, int xo1, bit xs1, int xh2, int xl2, int xo2, bit xs2, bit xb1);
      int p1, p2;
      h1 = 4'(xh1); l1 = 4'(xl1); o1 = 4'(xo1); s1 = xs1; b1 = xb1;
      h2 = 4'(xh2); l2 = 4'(xl2); o2 = 4'(xo2); s2 = xs2; b2 = 1'b0;
      frc = 1'b0; nsy = 1'b0;
      apply();
      p1 = xb1 ? 1 : xh1 + xl1 + 2;
      p2 = xh2 + xl2 + 2;
      run(p1 * (xo2 + 2 * p2) + xo1 + 3, "R6");
   endtask

   initial begin : watchdog
      #1_500_000;
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin : main
      // R10 reset state
      repeat (3) @(negedge clk);
      chk(clk_out, 1'b0, "R10", "output during reset");
      rst_n = 1'b1;

      // R1 R2 R3 single-stage sweep, second stage bypassed
      for (int h = 0; h < 4; h++)
         for (int l = 0; l < 4; l++)
            for (int o = 0; o < 3; o++)
               for (int s = 0; s < 2; s++) begin
                  h1 = 4'(h); l1 = 4'(l); o1 = 4'(o); s1 = s[0]; b1 = 1'b0;
                  b2 = 1'b1; frc = 1'b0; nsy = 1'b0;
                  apply();
                  run(o + 2 * (h + l + 2) + 2, (o > 0) ? "R2" : (s != 0) ? "R3" : "R1");
               end

      // R1 R2 maximum counts and offset
      h1 = 4'd15; l1 = 4'd15; o1 = 4'd15; s1 = 1'b1; b1 = 1'b0; b2 = 1'b1;
      apply();
      run(15 + 2 * 32 + 2, "R1");
      h1 = 4'd14; l1 = 4'd3; o1 = 4'd15; s1 = 1'b0;
      apply();
      run(15 + 2 * 19 + 2, "R2");

      // R6 cascade
      casc(0, 0, 0, 1'b0, 0, 0, 0, 1'b0, 1'b0);
      casc(1, 0, 0, 1'b1, 2, 1, 0, 1'b0, 1'b0);
      casc(0, 2, 1, 1'b0, 1, 0, 1, 1'b1, 1'b0);
      casc(2, 1, 0, 1'b1, 0, 3, 2, 1'b1, 1'b0);
      casc(0, 0, 0, 1'b0, 2, 3, 1, 1'b1, 1'b1);

      // R4 force-high with dividing and with bypass
      h1 = 4'd1; l1 = 4'd1; o1 = 4'd0; s1 = 1'b0; b1 = 1'b0; b2 = 1'b1; frc = 1'b1;
      apply();
      for (int k = 0; k < 8; k++) begin
         @(posedge clk); #2 chk(clk_out, 1'b1, "R4", "forced, high half");
         @(negedge clk); #2 chk(clk_out, 1'b1, "R4", "forced, low half");
      end
      b1 = 1'b1; b2 = 1'b1;
      apply();
      for (int k = 0; k < 4; k++) begin
         @(posedge clk); #2 chk(clk_out, 1'b1, "R4", "forced bypass, high half");
         @(negedge clk); #2 chk(clk_out, 1'b1, "R4", "forced bypass, low half");
      end

      // R5 full bypass
      frc = 1'b0;
      apply();
      for (int k = 0; k < 8; k++) begin
         @(posedge clk); #2 chk(clk_out, 1'b1, "R5", "bypass high half");
         @(negedge clk); #2 chk(clk_out, 1'b0, "R5", "bypass low half");
      end

      // R7 sync hold and release
      h1 = 4'd1; l1 = 4'd2; o1 = 4'd1; s1 = 1'b1; b1 = 1'b0; b2 = 1'b1; nsy = 1'b0;
      apply();
      run(5, "R7");
      @(negedge clk);
      sync_in = 1'b1;
      repeat (4) @(negedge clk);
      for (int k = 0; k < 6; k++) begin
         if (k > 0) @(negedge clk);
         chk(clk_out, 1'b1, "R7", "parked at start level");
      end
      sync_in = 1'b0;
      repeat (2) @(negedge clk);
      run(14, "R7");

      // R7 with cascade, start level from second stage
      casc(0, 1, 0, 1'b1, 1, 0, 0, 1'b0, 1'b0);
      @(negedge clk);
      sync_in = 1'b1;
      repeat (4) @(negedge clk);
      for (int k = 0; k < 4; k++) begin
         if (k > 0) @(negedge clk);
         chk(clk_out, 1'b0, "R7", "cascade parked");
      end
      sync_in = 1'b0;
      repeat (2) @(negedge clk);
      run(20, "R7");

      // R8 no-sync ignores sync_in
      h1 = 4'd2; l1 = 4'd0; o1 = 4'd0; s1 = 1'b0; b1 = 1'b0; b2 = 1'b1; nsy = 1'b1;
      apply();
      for (int j = 0; j < 30; j++) begin
         if (j > 0) @(negedge clk);
         chk(clk_out, exp_out(j), "R8", $sformatf("no-sync sample %0d", j));
         sync_in = (j >= 5 && j < 15);
      end
      sync_in = 1'b0;
      nsy = 1'b0;

      // R9 inputs change without strobe, then with strobe
      h1 = 4'd2; l1 = 4'd1; o1 = 4'd0; s1 = 1'b1; b1 = 1'b0; b2 = 1'b1;
      apply();
      for (int j = 0; j < 24; j++) begin
         if (j > 0) @(negedge clk);
         chk(clk_out, exp_out(j), "R9", $sformatf("held settings sample %0d", j));
         if (j == 4) begin
            h1 = 4'd0; l1 = 4'd0; s1 = 1'b0; o1 = 4'd3; b1 = 1'b1; frc = 1'b1;
         end
      end
      b1 = 1'b0; frc = 1'b0;
      apply();
      run(12, "R9");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule